// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block takes a bank of level-sensitive interrupt request lines and sorts them into two processor-facing outputs. The first is a fast request that carries no vector. The second is a normal request that is vectored. Software chooses the output for each line with a select bitmask. It turns lines on with a write-ones-to-set enable mask and turns them off with a write-ones-to-clear companion register.

A set of numbered slots binds source numbers to handler addresses. Each slot has an address register and a control word. The control word holds an enable bit and the source number. When the handler reads the vector register, it gets the address of the best-placed active slot. A lower slot number wins. A pending normal-class line that no enabled slot claims is served through a default address.

The vector read also records the winner's priority level as in service. From then on, only strictly higher-priority slots can raise the normal request. A write of any value to the vector register ends service of the most recent level. Levels nest, so a higher-priority handler can preempt a lower one and each write unwinds one step.

Top module: `intvec_ctrl`

## Requirements
- R1: After reset the enable mask, select mask, default address and in-service state are all zero. Both request outputs are low. A read of the vector register at word offset 0x06 returns 0.
- R2: Word offset 0x00 reads back the raw input lines. Offset 0x01 reads the lines that are both enabled and routed to the normal class.
- R3: The select register at offset 0x02 has one bit per source, where 1 means fast class and 0 means normal class. `fiq_o` is high exactly when some line is active, enabled and of fast class. Fast-class lines never take part in vectoring.
- R4: Writing to offset 0x03 sets each enable bit whose written bit is 1 and leaves the bits written 0 unchanged. A read of 0x03 returns the enable mask.
- R5: Writing to offset 0x04 clears each enable bit whose written bit is 1 and leaves the bits written 0 unchanged.
- R6: Slot k has its handler address at offset 0x20+k and its control word at 0x30+k. In the control word, bit 5 enables the slot and bits 4:0 hold the source number. For example, 0x24 binds source 4 and 0x26 binds source 6. Both registers read back.
- R7: A read of offset 0x06 returns the address of the lowest-numbered enabled slot that meets two conditions. Its source must be active, enabled and of normal class. Its number must be below the current in-service level.
- R8: Sometimes no slot is eligible while an enabled normal-class line that no enabled slot names is active and nothing is in service. Then `irq_o` is high and a vector read returns the default address at offset 0x05. Whenever nothing is eligible, a vector read returns the default address and changes no state.
- R9: A vector read that returns an eligible result marks that level as in service. After that, a slot of the same or lower priority cannot raise `irq_o`, but a higher-priority slot can.
- R10: A write of any value to offset 0x06 ends service of the most recently marked level, which is the highest-priority one held. Any level held underneath then applies again.
- R11: `irq_o` is high exactly when a vector read would return an eligible result. With all lines low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NSRC (32) | Level interrupt request lines |
| bus_sel_i | input | 1 | Register access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word offset of the register |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Normal, vectored request |
| fiq_o | output | 1 | Fast, unvectored request |

## Verification
The hardest state to reach is nested service. A lower slot is latched, a higher slot arrives and is latched over it, and the two end-of-service writes then have to unwind the levels in order while a line stays active at the level still held. The directed part builds exactly this sequence, with a default-address level also held underneath a vectored one. The random part interleaves vector reads and writes with changing lines and slot bindings to sources 0 to 7, so that nesting several levels deep happens often. A bench model predicts every vector value and both outputs.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned REG_AW     = 6;
  localparam int unsigned CTL_EN_BIT = 5;

  localparam logic [REG_AW-1:0] OFS_RAW      = 6'h00;
  localparam logic [REG_AW-1:0] OFS_IRQSTAT  = 6'h01;
  localparam logic [REG_AW-1:0] OFS_SELECT   = 6'h02;
  localparam logic [REG_AW-1:0] OFS_ENSET    = 6'h03;
  localparam logic [REG_AW-1:0] OFS_ENCLR    = 6'h04;
  localparam logic [REG_AW-1:0] OFS_DFLT     = 6'h05;
  localparam logic [REG_AW-1:0] OFS_VECT     = 6'h06;
  localparam logic [REG_AW-1:0] OFS_SLOTADDR = 6'h20;
  localparam logic [REG_AW-1:0] OFS_SLOTCTL  = 6'h30;
endpackage

// File: rtl/ivc_regfile.sv
module ivc_regfile
  import ivc_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned SRC_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [NSRC-1:0]   sel_q,
  output logic [NSRC-1:0]   en_q,
  output logic [DW-1:0]     dflt_q,
  output logic [DW-1:0]     slot_addr_q [NSLOT],
  output logic [NSLOT-1:0]  slot_en_q,
  output logic [SRC_W-1:0]  slot_src_q [NSLOT]
);

  logic [NSRC-1:0] sel_d;
  logic [NSRC-1:0] en_d;
  logic [DW-1:0]   dflt_d;

  always_comb begin
    sel_d  = sel_q;
    en_d   = en_q;
    dflt_d = dflt_q;
    if (wr_en) begin
      case (wr_addr)
        OFS_SELECT: sel_d  = wr_data[NSRC-1:0];
        OFS_ENSET:  en_d   = en_q | wr_data[NSRC-1:0];
        OFS_ENCLR:  en_d   = en_q & ~wr_data[NSRC-1:0];
        OFS_DFLT:   dflt_d = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      en_q   <= '0;
      dflt_q <= '0;
    end else begin
      sel_q  <= sel_d;
      en_q   <= en_d;
      dflt_q <= dflt_d;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [REG_AW-1:0] A_OFS = OFS_SLOTADDR + REG_AW'(g);
    localparam logic [REG_AW-1:0] C_OFS = OFS_SLOTCTL + REG_AW'(g);
    logic addr_we;
    logic ctl_we;

    assign addr_we = wr_en && (wr_addr == A_OFS);
    assign ctl_we  = wr_en && (wr_addr == C_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_addr_q[g] <= '0;
      end else if (addr_we) begin
        slot_addr_q[g] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_en_q[g]  <= 1'b0;
        slot_src_q[g] <= '0;
      end else if (ctl_we) begin
        slot_en_q[g]  <= wr_data[CTL_EN_BIT];
        slot_src_q[g] <= wr_data[SRC_W-1:0];
      end
    end
  end

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned SRC_W = $clog2(NSRC),
  parameter int unsigned LVL_W = $clog2(NSLOT + 2)
) (
  input  logic [NSRC-1:0]  pend,
  input  logic [NSLOT-1:0] slot_en_q,
  input  logic [SRC_W-1:0] slot_src_q [NSLOT],
  input  logic [LVL_W-1:0] svc_lvl,
  output logic             win_valid,
  output logic [LVL_W-1:0] win_lvl
);

  localparam logic [LVL_W-1:0] LVL_DFLT = LVL_W'(NSLOT);
  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NSLOT + 1);

  logic [NSLOT-1:0] slot_hit;
  logic [NSRC-1:0]  claimed;
  logic             orphan;

  for (genvar g = 0; g < NSLOT; g++) begin : g_hit
    assign slot_hit[g] = slot_en_q[g] && pend[slot_src_q[g]] &&
                         (LVL_W'(g) < svc_lvl);
  end

  always_comb begin
    claimed = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (slot_en_q[k]) claimed[slot_src_q[k]] = 1'b1;
    end
  end

  assign orphan = |(pend & ~claimed);

  always_comb begin
    win_valid = 1'b0;
    win_lvl   = LVL_DFLT;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (slot_hit[k]) begin
        win_valid = 1'b1;
        win_lvl   = LVL_W'(k);
      end
    end
    if (!win_valid && orphan && (svc_lvl == LVL_IDLE)) begin
      win_valid = 1'b1;
    end
  end

endmodule

// File: rtl/ivc_inservice.sv
module ivc_inservice #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned LVL_W = $clog2(NSLOT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             rel_i,
  input  logic [LVL_W-1:0] win_lvl,
  output logic [LVL_W-1:0] svc_lvl
);

  localparam int unsigned NLVL = NSLOT + 1;

  logic [NLVL-1:0] held_q;
  logic [NLVL-1:0] held_d;

  always_comb begin
    held_d = held_q;
    if (rel_i) begin
      held_d = held_q & (held_q - 1'b1);
    end else if (take_i && (win_lvl < LVL_W'(NLVL))) begin
      held_d[win_lvl] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  always_comb begin
    svc_lvl = LVL_W'(NLVL);
    for (int k = NLVL - 1; k >= 0; k--) begin
      if (held_q[k]) svc_lvl = LVL_W'(k);
    end
  end

endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_lines_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam int unsigned SRC_W   = $clog2(NSRC);
  localparam int unsigned LVL_W   = $clog2(NSLOT + 2);
  localparam int unsigned SLOT_IW = $clog2(NSLOT);

  logic [1:0]        rst_pipe;
  logic              rst_ns;
  logic [NSRC-1:0]   sel_q;
  logic [NSRC-1:0]   en_q;
  logic [DW-1:0]     dflt_q;
  logic [DW-1:0]     slot_addr_q [NSLOT];
  logic [NSLOT-1:0]  slot_en_q;
  logic [SRC_W-1:0]  slot_src_q [NSLOT];
  logic [NSRC-1:0]   pend;
  logic              win_valid;
  logic [LVL_W-1:0]  win_lvl;
  logic [LVL_W-1:0]  svc_lvl;
  logic              vec_hit;
  logic              take;
  logic              rel;
  logic [DW-1:0]     vec_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  ivc_regfile #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW), .SRC_W(SRC_W)) i_regfile (
    .clk         (clk),
    .rst_n       (rst_ns),
    .wr_en       (bus_sel_i && bus_we_i),
    .wr_addr     (bus_addr_i),
    .wr_data     (bus_wdata_i),
    .sel_q       (sel_q),
    .en_q        (en_q),
    .dflt_q      (dflt_q),
    .slot_addr_q (slot_addr_q),
    .slot_en_q   (slot_en_q),
    .slot_src_q  (slot_src_q)
  );

  assign pend  = irq_lines_i & en_q & ~sel_q;
  assign fiq_o = |(irq_lines_i & en_q & sel_q);

  ivc_arbiter #(.NSRC(NSRC), .NSLOT(NSLOT), .SRC_W(SRC_W), .LVL_W(LVL_W)) i_arbiter (
    .pend       (pend),
    .slot_en_q  (slot_en_q),
    .slot_src_q (slot_src_q),
    .svc_lvl    (svc_lvl),
    .win_valid  (win_valid),
    .win_lvl    (win_lvl)
  );

  assign vec_hit = bus_sel_i && (bus_addr_i == OFS_VECT);
  assign take    = vec_hit && !bus_we_i && win_valid;
  assign rel     = vec_hit && bus_we_i;

  ivc_inservice #(.NSLOT(NSLOT), .LVL_W(LVL_W)) i_inservice (
    .clk     (clk),
    .rst_n   (rst_ns),
    .take_i  (take),
    .rel_i   (rel),
    .win_lvl (win_lvl),
    .svc_lvl (svc_lvl)
  );

  assign irq_o = win_valid;

  always_comb begin
    vec_addr = dflt_q;
    if (win_valid && (win_lvl < LVL_W'(NSLOT))) begin
      vec_addr = slot_addr_q[win_lvl[SLOT_IW-1:0]];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      case (bus_addr_i)
        OFS_RAW:     bus_rdata_o[NSRC-1:0] = irq_lines_i;
        OFS_IRQSTAT: bus_rdata_o[NSRC-1:0] = pend;
        OFS_SELECT:  bus_rdata_o[NSRC-1:0] = sel_q;
        OFS_ENSET:   bus_rdata_o[NSRC-1:0] = en_q;
        OFS_DFLT:    bus_rdata_o = dflt_q;
        OFS_VECT:    bus_rdata_o = vec_addr;
        default: begin
          for (int k = 0; k < NSLOT; k++) begin
            if (bus_addr_i == (OFS_SLOTADDR + REG_AW'(k))) begin
              bus_rdata_o = slot_addr_q[k];
            end
            if (bus_addr_i == (OFS_SLOTCTL + REG_AW'(k))) begin
              bus_rdata_o[CTL_EN_BIT]  = slot_en_q[k];
              bus_rdata_o[SRC_W-1:0]   = slot_src_q[k];
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
#(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned NSLOT = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned LVL_W = $clog2(NSLOT + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [REG_AW-1:0] bus_addr_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic [NSRC-1:0]   irq_lines_i,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NSRC-1:0]   en_q,
  input logic [LVL_W-1:0]  svc_lvl,
  input logic              win_valid
);

  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NSLOT + 1);

  // R4: written ones appear in the enable mask
  a_r4_enset_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_we_i && bus_addr_i == OFS_ENSET)
    |=> ((en_q & $past(bus_wdata_i[NSRC-1:0])) == $past(bus_wdata_i[NSRC-1:0])));

  // R5: written ones are gone from the enable mask
  a_r5_enclr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_we_i && bus_addr_i == OFS_ENCLR)
    |=> ((en_q & $past(bus_wdata_i[NSRC-1:0])) == '0));

  // R9: an eligible vector read raises the held priority
  a_r9_take_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && !bus_we_i && bus_addr_i == OFS_VECT && win_valid)
    |=> (svc_lvl < $past(svc_lvl)));

  // R10: end-of-service write lowers the held priority
  a_r10_release_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_we_i && bus_addr_i == OFS_VECT && svc_lvl != LVL_IDLE)
    |=> (svc_lvl > $past(svc_lvl)));

  // R11: no active line, no request
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines_i == '0) |-> (!irq_o && !fiq_o));

endmodule

bind intvec_ctrl ivc_checker #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW), .LVL_W(LVL_W)) i_ivc_checker (
  .clk         (clk),
  .rst_n       (rst_ns),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_lines_i (irq_lines_i),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .en_q        (en_q),
  .svc_lvl     (svc_lvl),
  .win_valid   (win_valid)
);

// File: tb/test_intvec_ctrl.sv
`timescale 1ns/1ps
module test_intvec_ctrl;
  localparam int NSRC = 32;
  localparam int NSLOT = 16;
  localparam logic [5:0] A_RAW = 6'h00, A_IST = 6'h01, A_SEL = 6'h02, A_ENS = 6'h03,
                         A_ENC = 6'h04, A_DFL = 6'h05, A_VEC = 6'h06;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_fail = 0;

  // bench model of software-visible state
  logic [31:0] m_sel, m_en, m_dflt;
  logic [31:0] m_saddr [NSLOT];
  logic        m_sen   [NSLOT];
  logic [4:0]  m_ssrc  [NSLOT];
  logic [16:0] m_held;

  always #2.5 clk = ~clk;

  intvec_ctrl #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(32)) i_intvec_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .bus_sel_i(bus_sel),
    .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic int m_level();
    for (int k = 0; k < 17; k++) if (m_held[k]) return k;
    return 17;
  endfunction

  // -1: nothing eligible, 0..15 slot, 16 default
  function automatic int m_win();
    logic [31:0] pend = lines & m_en & ~m_sel;
    logic [31:0] claimed = '0;
    int lv = m_level();
    for (int k = 0; k < NSLOT; k++) if (m_sen[k]) claimed[m_ssrc[k]] = 1'b1;
    for (int k = 0; k < NSLOT; k++)
      if (m_sen[k] && pend[m_ssrc[k]] && k < lv) return k;
    if ((pend & ~claimed) != 0 && lv == 17) return 16;
    return -1;
  endfunction

  function automatic logic [31:0] m_vec();
    int w = m_win();
    if (w >= 0 && w < 16) return m_saddr[w];
    return m_dflt;
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    if (a == A_RAW) return lines;
    if (a == A_IST) return lines & m_en & ~m_sel;
    if (a == A_SEL) return m_sel;
    if (a == A_ENS) return m_en;
    if (a == A_DFL) return m_dflt;
    if (a == A_VEC) return m_vec();
    if (a >= 6'h20 && a < 6'h30) return m_saddr[a - 6'h20];
    if (a >= 6'h30) return {26'b0, m_sen[a - 6'h30], m_ssrc[a - 6'h30]};
    return 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_out(string req);
    chk({req, " irq_o"}, {31'b0, irq_o}, {31'b0, m_win() >= 0});
    chk({req, " fiq_o"}, {31'b0, fiq_o}, {31'b0, |(lines & m_en & m_sel)});
  endtask

  task automatic bus_op(logic we, logic [5:0] a, logic [31:0] d, output logic [31:0] rd);
    int w;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    rd = bus_rdata;
    w = m_win();
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0;
    if (we) begin
      if (a == A_SEL) m_sel = d;
      else if (a == A_ENS) m_en = m_en | d;
      else if (a == A_ENC) m_en = m_en & ~d;
      else if (a == A_DFL) m_dflt = d;
      else if (a == A_VEC) m_held = m_held & (m_held - 17'd1);
      else if (a >= 6'h20 && a < 6'h30) m_saddr[a - 6'h20] = d;
      else if (a >= 6'h30) begin m_sen[a - 6'h30] = d[5]; m_ssrc[a - 6'h30] = d[4:0]; end
    end else if (a == A_VEC && w >= 0) begin
      m_held[w] = 1'b1;
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    logic [31:0] rd;
    bus_op(1'b1, a, d, rd);
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
    logic [31:0] rd;
    bus_op(1'b0, a, 32'h0, rd);
    chk(req, rd, exp);
  endtask

  task automatic set_lines(logic [31:0] v);
    @(negedge clk);
    lines = v;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    m_sel = '0; m_en = '0; m_dflt = '0; m_held = '0;
    for (int k = 0; k < NSLOT; k++) begin m_saddr[k] = '0; m_sen[k] = 1'b0; m_ssrc[k] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state
    chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
    chk("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
    rd_chk("R1 enable", A_ENS, 32'h0);
    rd_chk("R1 select", A_SEL, 32'h0);
    rd_chk("R1 vector", A_VEC, 32'h0);

    // R6 slot binding
    wr(6'h20, 32'h0000_1000);
    wr(6'h21, 32'h0000_2000);
    wr(6'h30, 32'h24);
    wr(6'h31, 32'h26);
    wr(A_ENS, 32'h50);
    wr(A_DFL, 32'hDEAD_0000);
    rd_chk("R6 ctl0", 6'h30, 32'h24);
    rd_chk("R6 addr1", 6'h21, 32'h2000);
    rd_chk("R4 enable readback", A_ENS, 32'h50);

    // R7/R9/R10 nesting
    set_lines(32'h40);
    chk("R11 irq_o on src6", {31'b0, irq_o}, 32'h1);
    rd_chk("R7 vector slot1", A_VEC, 32'h2000);
    chk("R9 same level masked", {31'b0, irq_o}, 32'h0);
    set_lines(32'h50);
    chk("R9 higher slot passes", {31'b0, irq_o}, 32'h1);
    rd_chk("R7 vector slot0", A_VEC, 32'h1000);
    chk("R9 both held", {31'b0, irq_o}, 32'h0);
    wr(A_VEC, 32'h0);
    chk("R10 release slot0", {31'b0, irq_o}, 32'h1);
    set_lines(32'h40);
    chk("R10 slot1 still held", {31'b0, irq_o}, 32'h0);
    wr(A_VEC, 32'h0);
    chk("R10 release slot1", {31'b0, irq_o}, 32'h1);
    rd_chk("R7 vector again", A_VEC, 32'h2000);
    wr(A_VEC, 32'h0);

    // R2/R8 unclaimed source -> default
    set_lines(32'h200);
    chk("R8 not enabled yet", {31'b0, irq_o}, 32'h0);
    wr(A_ENS, 32'h200);
    rd_chk("R2 raw", A_RAW, 32'h200);
    rd_chk("R2 irq status", A_IST, 32'h200);
    chk("R8 irq_o default", {31'b0, irq_o}, 32'h1);
    rd_chk("R8 default vector", A_VEC, 32'hDEAD_0000);
    chk("R8 default held", {31'b0, irq_o}, 32'h0);
    set_lines(32'h240);
    rd_chk("R9 slot over default", A_VEC, 32'h2000);
    wr(A_VEC, 32'h0);
    wr(A_VEC, 32'h0);
    set_lines(32'h0);
    rd_chk("R8 nothing eligible", A_VEC, 32'hDEAD_0000);

    // R4/R5 enable semantics
    wr(A_ENC, 32'h10);
    rd_chk("R5 clear bit4", A_ENS, 32'h240);
    wr(A_ENC, 32'h0);
    rd_chk("R5 zero write no effect", A_ENS, 32'h240);
    wr(A_ENS, 32'h0);
    rd_chk("R4 zero write no effect", A_ENS, 32'h240);

    // R3 fast class
    wr(A_SEL, 32'h40);
    set_lines(32'h40);
    chk("R3 fiq_o", {31'b0, fiq_o}, 32'h1);
    chk("R3 fast not vectored", {31'b0, irq_o}, 32'h0);
    rd_chk("R3 irq status excludes fast", A_IST, 32'h0);
    wr(A_SEL, 32'h0);
    wr(A_ENC, 32'hFFFF_FFFF);
    set_lines(32'h0);
    chk_out("R11 directed end");

    // random phase
    for (int it = 0; it < 4000; it++) begin
      int r = int'($urandom % 10);
      logic [31:0] rv = $urandom;
      logic [31:0] rd;
      case (r)
        0, 1, 2: set_lines(rv & $urandom);
        3: begin
          logic [31:0] exp = m_vec();
          bus_op(1'b0, A_VEC, 32'h0, rd);
          chk("R7 random vector", rd, exp);
        end
        4: wr(A_VEC, rv);
        5: wr(6'h30 + 6'(rv[3:0]), {26'b0, rv[8], 2'b0, rv[6:4]});
        6: wr(6'h20 + 6'(rv[3:0]), $urandom);
        7: if (rv[4]) wr(A_ENS, $urandom); else wr(A_ENC, $urandom & $urandom);
        8: if (rv[0]) wr(A_SEL, $urandom & $urandom & $urandom); else wr(A_DFL, $urandom);
        default: begin
          logic [5:0] a = rv[1] ? 6'(6'h20 + rv[8:4]) : 6'(rv[6:4] % 6);
          logic [31:0] exp = m_read(a);
          bus_op(1'b0, a, 32'h0, rd);
          chk("R2 random readback", rd, exp);
        end
      endcase
      chk_out("R11 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule